// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

A 64-entry, 36-bit first-in first-out buffer that carries words one way, from a write port on one free-running clock to a read port on another. The two clocks may be unrelated or the same net. Each port has an active-low select, an active-high enable and a direction input. A port moves a word on a rising edge of its own clock only when all three agree.

The write side reports a Full flag and an Almost-Full flag. The read side reports an Empty flag and an Almost-Empty flag. Each flag is driven by local pointer state and by the other side's Gray-coded pointer, which passes through a two-flop synchronizer. All four flags are active-low: a LOW output means the condition holds.

An almost-flag threshold X is picked from four presets by a two-bit select. The select is captured on reset release and has no effect afterwards. The single active-low reset asserts asynchronously. Each clock domain releases it through its own two-flop synchronizer.

Top module: `xclk_fifo`

## Requirements
- R1: While rst_ni is LOW, full_no, afull_no, empty_no and aempty_no are all LOW and rdata_o is zero.
- R2: After rst_ni rises between write-clock edges, full_no stays LOW after the first following write-clock edge and is HIGH after the second.
- R3: A write occurs only when w_cs_ni is LOW, w_en_i is HIGH and w_dir_i is HIGH. A read occurs only when r_cs_ni is LOW, r_en_i is HIGH and r_dir_i is LOW. Any other combination leaves the stored contents and the read pointer unchanged.
- R4: Words leave in the order they were written, with all 36 bits intact. A read loads rdata_o on the read-clock edge that performs it.
- R5: After a word is written into an empty FIFO, empty_no is HIGH after the second following read-clock edge, and still LOW after the first.
- R6: While full_no is LOW (64 words stored), write requests are ignored and the stored words are not disturbed.
- R7: While empty_no is LOW, read requests are ignored: rdata_o holds its value and no word is consumed.
- R8: aempty_no is LOW when the word count seen by the read side is less than or equal to X, and HIGH otherwise.
- R9: afull_no is LOW when the number of free entries seen by the write side is less than or equal to X, and HIGH otherwise.
- R10: X is fixed by ofs_sel_i as sampled at reset release: 00 gives 16, 01 gives 12, 10 gives 8, 11 gives 4. Later changes on ofs_sel_i do not move X.
- R11: A read from a full FIFO makes full_no HIGH after the second following write-clock edge, and it is still LOW after the first. Gray pointers change by exactly one bit per transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write-port clock |
| rclk_i | input | 1 | Read-port clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| ofs_sel_i | input | 2 | Almost-flag threshold select, captured at reset release |
| w_cs_ni | input | 1 | Write-port select, active low |
| w_en_i | input | 1 | Write-port enable |
| w_dir_i | input | 1 | Write-port direction, HIGH requests a write |
| wdata_i | input | 36 | Write data |
| full_no | output | 1 | LOW when the FIFO is full |
| afull_no | output | 1 | LOW when free entries are at or below X |
| r_cs_ni | input | 1 | Read-port select, active low |
| r_en_i | input | 1 | Read-port enable |
| r_dir_i | input | 1 | Read-port direction, LOW requests a read |
| rdata_o | output | 36 | Read data register |
| empty_no | output | 1 | LOW when the FIFO is empty |
| aempty_no | output | 1 | LOW when stored words are at or below X |

## Verification
A port's own flag reacts to its own transfers on the transfer edge itself. Examples are Almost-Full after a write, Empty after the last read, and rdata_o after a read. These are checked two time units after that edge. A flag that depends on the other port's pointer is due only after two edges of its own clock, for example Empty and Almost-Empty after a write, or Full after a read. The bench waits exactly two edges before checking these, and it also checks after one edge that the old value still holds. Full release after reset is checked the same way, one edge and two edges after rst_ni rises.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int unsigned DATA_W_DEF   = 36;
  localparam int unsigned ADDR_W_DEF   = 6;
  localparam int unsigned SYNC_DEF     = 2;
  localparam int unsigned OFS_BASE_DEF = 16;
  localparam int unsigned OFS_STEP_DEF = 4;
  localparam int unsigned SEL_W        = 2;
endpackage

// File: rtl/xf_rst_sync.sv
module xf_rst_sync #(
  parameter int unsigned STAGES = xf_pkg::SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/xf_ptr_sync.sv
module xf_ptr_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = xf_pkg::SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else             stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/xf_wr_ctrl.sv
module xf_wr_ctrl #(
  parameter int unsigned ADDR_W   = xf_pkg::ADDR_W_DEF,
  parameter int unsigned STAGES   = xf_pkg::SYNC_DEF,
  parameter int unsigned OFS_BASE = xf_pkg::OFS_BASE_DEF,
  parameter int unsigned OFS_STEP = xf_pkg::OFS_STEP_DEF,
  localparam int unsigned PTR_W   = ADDR_W + 1,
  localparam int unsigned DEPTH   = 1 << ADDR_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    en_i,
  input  logic                    dir_i,
  input  logic [xf_pkg::SEL_W-1:0] ofs_sel_i,
  input  logic [PTR_W-1:0]        rgray_i,
  output logic [PTR_W-1:0]        wgray_o,
  output logic [ADDR_W-1:0]       waddr_o,
  output logic                    wfire_o,
  output logic                    full_no,
  output logic                    afull_no
);
  function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] wbin_q, wbin_nx, wgray_q, rsync, rsync_bin, used, free, ofs_q, ofs_pick;
  logic full_c;

  xf_ptr_sync #(.WIDTH(PTR_W), .STAGES(STAGES)) u_rsync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rgray_i), .q_o(rsync)
  );

  assign rsync_bin = g2b(rsync);
  assign used      = wbin_q - rsync_bin;
  assign free      = PTR_W'(DEPTH) - used;
  assign full_c    = (wgray_q == {~rsync[PTR_W-1:PTR_W-2], rsync[PTR_W-3:0]});
  assign full_no   = rst_ni & ~full_c;
  assign afull_no  = rst_ni & (free > ofs_q);
  assign wfire_o   = ~cs_ni & en_i & dir_i & full_no;
  assign wbin_nx   = wbin_q + PTR_W'(wfire_o);
  assign ofs_pick  = PTR_W'(OFS_BASE) - PTR_W'(OFS_STEP) * PTR_W'(ofs_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  // threshold follows the select pins until the local reset releases
  always_ff @(posedge clk_i) begin
    if (!rst_ni) ofs_q <= ofs_pick;
  end

  assign wgray_o = wgray_q;
  assign waddr_o = wbin_q[ADDR_W-1:0];

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used <= PTR_W'(DEPTH));
  p_full_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |=> $stable(wbin_q));
  p_gray_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wfire_o |=> $countones(wgray_q ^ $past(wgray_q)) == 1);
  p_full_in_afull_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> !afull_no);
  p_ofs_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(ofs_q));
endmodule

// File: rtl/xf_rd_ctrl.sv
module xf_rd_ctrl #(
  parameter int unsigned ADDR_W   = xf_pkg::ADDR_W_DEF,
  parameter int unsigned STAGES   = xf_pkg::SYNC_DEF,
  parameter int unsigned OFS_BASE = xf_pkg::OFS_BASE_DEF,
  parameter int unsigned OFS_STEP = xf_pkg::OFS_STEP_DEF,
  localparam int unsigned PTR_W   = ADDR_W + 1,
  localparam int unsigned DEPTH   = 1 << ADDR_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    en_i,
  input  logic                    dir_i,
  input  logic [xf_pkg::SEL_W-1:0] ofs_sel_i,
  input  logic [PTR_W-1:0]        wgray_i,
  output logic [PTR_W-1:0]        rgray_o,
  output logic [ADDR_W-1:0]       raddr_o,
  output logic                    rfire_o,
  output logic                    empty_no,
  output logic                    aempty_no
);
  function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] rbin_q, rbin_nx, rgray_q, wsync, wsync_bin, count, ofs_q, ofs_pick;

  xf_ptr_sync #(.WIDTH(PTR_W), .STAGES(STAGES)) u_wsync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wgray_i), .q_o(wsync)
  );

  assign wsync_bin = g2b(wsync);
  assign count     = wsync_bin - rbin_q;
  assign empty_no  = rst_ni & (rgray_q != wsync);
  assign aempty_no = rst_ni & (count > ofs_q);
  assign rfire_o   = ~cs_ni & en_i & ~dir_i & empty_no;
  assign rbin_nx   = rbin_q + PTR_W'(rfire_o);
  assign ofs_pick  = PTR_W'(OFS_BASE) - PTR_W'(OFS_STEP) * PTR_W'(ofs_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ofs_q <= ofs_pick;
  end

  assign rgray_o = rgray_q;
  assign raddr_o = rbin_q[ADDR_W-1:0];

  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= PTR_W'(DEPTH));
  p_empty_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_no |=> $stable(rbin_q));
  p_rgray_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfire_o |=> $countones(rgray_q ^ $past(rgray_q)) == 1);
  p_empty_in_aempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no);
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int unsigned DATA_W   = xf_pkg::DATA_W_DEF,
  parameter int unsigned ADDR_W   = xf_pkg::ADDR_W_DEF,
  parameter int unsigned STAGES   = xf_pkg::SYNC_DEF,
  parameter int unsigned OFS_BASE = xf_pkg::OFS_BASE_DEF,
  parameter int unsigned OFS_STEP = xf_pkg::OFS_STEP_DEF
) (
  input  logic                     wclk_i,
  input  logic                     rclk_i,
  input  logic                     rst_ni,
  input  logic [xf_pkg::SEL_W-1:0] ofs_sel_i,
  input  logic                     w_cs_ni,
  input  logic                     w_en_i,
  input  logic                     w_dir_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic                     full_no,
  output logic                     afull_no,
  input  logic                     r_cs_ni,
  input  logic                     r_en_i,
  input  logic                     r_dir_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     empty_no,
  output logic                     aempty_no
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic rst_w_n, rst_r_n, wfire, rfire;
  logic [PTR_W-1:0]  wgray, rgray;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] mem_q [DEPTH];

  xf_rst_sync #(.STAGES(STAGES)) u_wrst (.clk_i(wclk_i), .rst_ni(rst_ni), .rst_no(rst_w_n));
  xf_rst_sync #(.STAGES(STAGES)) u_rrst (.clk_i(rclk_i), .rst_ni(rst_ni), .rst_no(rst_r_n));

  xf_wr_ctrl #(.ADDR_W(ADDR_W), .STAGES(STAGES), .OFS_BASE(OFS_BASE), .OFS_STEP(OFS_STEP)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_w_n), .cs_ni(w_cs_ni), .en_i(w_en_i), .dir_i(w_dir_i),
    .ofs_sel_i(ofs_sel_i), .rgray_i(rgray), .wgray_o(wgray), .waddr_o(waddr),
    .wfire_o(wfire), .full_no(full_no), .afull_no(afull_no)
  );

  xf_rd_ctrl #(.ADDR_W(ADDR_W), .STAGES(STAGES), .OFS_BASE(OFS_BASE), .OFS_STEP(OFS_STEP)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_r_n), .cs_ni(r_cs_ni), .en_i(r_en_i), .dir_i(r_dir_i),
    .ofs_sel_i(ofs_sel_i), .wgray_i(wgray), .rgray_o(rgray), .raddr_o(raddr),
    .rfire_o(rfire), .empty_no(empty_no), .aempty_no(aempty_no)
  );

  always_ff @(posedge wclk_i) begin
    if (wfire) mem_q[waddr] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_r_n) begin
    if (!rst_r_n)   rdata_o <= '0;
    else if (rfire) rdata_o <= mem_q[raddr];
  end

  p_rdata_hold_r7: assert property (@(posedge rclk_i) disable iff (!rst_r_n)
    !empty_no |=> $stable(rdata_o));
endmodule

// File: tb/xclk_fifo_test.sv
module xclk_fifo_test;
  localparam int DW = 36;
  localparam int DEPTH = 64;

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] ofs;
  } vec_t;
  // R10: select code -> threshold
  localparam vec_t VECS [4] = '{'{2'b00, 8'd16}, '{2'b01, 8'd12}, '{2'b10, 8'd8}, '{2'b11, 8'd4}};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, w_cs_n, w_en, w_dir, r_cs_n, r_en, r_dir;
  logic [1:0] sel;
  logic [DW-1:0] wdata, rdata;
  logic full_n, afull_n, empty_n, aempty_n;
  int n_chk = 0;
  int n_bad = 0;

  xclk_fifo uut (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .ofs_sel_i(sel),
    .w_cs_ni(w_cs_n), .w_en_i(w_en), .w_dir_i(w_dir), .wdata_i(wdata),
    .full_no(full_n), .afull_no(afull_n),
    .r_cs_ni(r_cs_n), .r_en_i(r_en), .r_dir_i(r_dir), .rdata_o(rdata),
    .empty_no(empty_n), .aempty_no(aempty_n)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int i);
    return (DW'(i) * 36'h9_E377_9B97) ^ 36'hF_0F0F_0F0F;
  endfunction

  task automatic push(logic [DW-1:0] d);
    w_cs_n = 1'b0; w_en = 1'b1; w_dir = 1'b1; wdata = d;
    step(1);
    w_cs_n = 1'b1; w_en = 1'b0;
  endtask

  task automatic pop();
    r_cs_n = 1'b0; r_en = 1'b1; r_dir = 1'b0;
    step(1);
    r_cs_n = 1'b1; r_en = 1'b0;
  endtask

  task automatic apply_reset(logic [1:0] s);
    rst_n = 1'b0; sel = s;
    step(2);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sel = 2'b00;
    w_cs_n = 1'b1; w_en = 1'b0; w_dir = 1'b0; wdata = '0;
    r_cs_n = 1'b1; r_en = 1'b0; r_dir = 1'b0;
    step(3);

    // R1: all flags LOW in reset
    check("R1 full", full_n, 0);
    check("R1 afull", afull_n, 0);
    check("R1 empty", empty_n, 0);
    check("R1 aempty", aempty_n, 0);
    check("R1 rdata", rdata, 0);

    // R2: full release timing
    rst_n = 1'b1;
    step(1);
    check("R2 edge1", full_n, 0);
    step(1);
    check("R2 edge2", full_n, 1);
    check("R9 idle", afull_n, 1);

    // R7: read on empty ignored
    pop();
    check("R7 rdata", rdata, 0);
    check("R7 empty", empty_n, 0);

    // R3: write gating
    wdata = 36'h5_5555_5555;
    w_cs_n = 1'b1; w_en = 1'b1; w_dir = 1'b1; step(1);
    w_cs_n = 1'b0; w_en = 1'b0; step(1);
    w_en = 1'b1; w_dir = 1'b0; step(1);
    w_cs_n = 1'b1; w_en = 1'b0;
    step(2);
    check("R3 write gated", empty_n, 0);

    // R5: empty release two read edges after write
    push(pat(100));
    check("R5 edge0", empty_n, 0);
    step(1);
    check("R5 edge1", empty_n, 0);
    step(1);
    check("R5 edge2", empty_n, 1);

    // R3: read gating
    r_cs_n = 1'b1; r_en = 1'b1; r_dir = 1'b0; step(1);
    r_cs_n = 1'b0; r_en = 1'b0; step(1);
    r_en = 1'b1; r_dir = 1'b1; step(1);
    r_cs_n = 1'b1; r_en = 1'b0; r_dir = 1'b0;
    check("R3 read gated rdata", rdata, 0);
    check("R3 read gated empty", empty_n, 1);

    // R4: data and order
    pop();
    check("R4 first word", rdata, pat(100));
    check("R4 empty after last", empty_n, 0);
    for (int i = 1; i <= 5; i++) push(pat(i));
    step(2);
    for (int i = 1; i <= 5; i++) begin
      pop();
      check("R4 order", rdata, pat(i));
    end

    // R8 R9 R10 R6: walk the threshold table
    for (int v = 0; v < 4; v++) begin
      int x;
      x = int'(VECS[v].ofs);
      apply_reset(VECS[v].sel);
      sel = ~VECS[v].sel;
      for (int i = 0; i < x; i++) push(pat(i));
      step(2);
      check("R8 count==X", aempty_n, 0);
      push(pat(x));
      step(2);
      check("R8 R10 count==X+1", aempty_n, 1);
      for (int i = x + 1; i < DEPTH - x - 1; i++) push(pat(i));
      check("R9 free==X+1", afull_n, 1);
      push(pat(DEPTH - x - 1));
      check("R9 R10 free==X", afull_n, 0);
      for (int i = DEPTH - x; i < DEPTH; i++) push(pat(i));
      check("R6 full at 64", full_n, 0);
    end

    // R6 R11: full, overflow attempt, drain
    apply_reset(2'b00);
    for (int i = 0; i < DEPTH; i++) push(pat(i));
    check("R6 full", full_n, 0);
    push(36'h1_2345_6789);
    step(2);
    pop();
    check("R4 head after full", rdata, pat(0));
    check("R11 edge0", full_n, 0);
    step(1);
    check("R11 edge1", full_n, 0);
    step(1);
    check("R11 edge2", full_n, 1);
    for (int i = 1; i < DEPTH; i++) begin
      pop();
      check("R6 drain order", rdata, pat(i));
    end
    check("R6 no extra word", empty_n, 0);
    pop();
    check("R7 hold after drain", rdata, pat(DEPTH - 1));

    finish_run();
  end
endmodule